// File: doc/BRIEF.md
# Machine-Mode Trap State Controller

This block keeps the trap bookkeeping of a single-hart, 32-bit core that runs only at the machine privilege level. It holds the status word with its two-level interrupt-enable stack, the exception PC, the cause word, the trap value word and a scratch word. When the pipeline raises a trap, it presents the resume PC, a cause code, an interrupt flag and an information word (a faulting address or the instruction bits). In the cycle after acceptance, every affected register holds its new value.

A return strobe pops the enable stack and the block drives the saved exception PC as the return target. A plain CSR port reads and writes the five registers. Reads are combinational on the address. Writes take effect at the next clock edge.

The trap request is a valid/ready input. `trap_ready` is low during reset and from the first clock after reset it stays high, so the block never applies back-pressure. A request is taken in any cycle where both `trap_valid` and `trap_ready` are high. A trap that arrives during reset is dropped, and the pipeline must hold it until `trap_ready` is high.

Top module: `mtrap_ctrl`

## Requirements
- R1: `trap_ready` is 0 while `rst_n` is low and is 1 from the first rising edge after reset onward. A trap is accepted when `trap_valid && trap_ready`, and all register updates are visible after the next rising edge.
- R2: On trap acceptance, the previous-enable bit takes the current global enable, the global enable becomes 0, and the saved-privilege field becomes 2'b11.
- R3: The exception PC (address 0x341) is loaded with `trap_pc` with bits 1:0 cleared on a trap. Software writes also have bits 1:0 forced to 0.
- R4: On a trap, the cause word (0x342) gets bit 31 = `trap_is_irq`, bits 4:0 = `trap_code` and zeros elsewhere. A software write keeps only bits 31 and 4:0 (writing 0xFFFFFFFF reads back 0x8000001F).
- R5: For an exception whose code is 0, 1, 3, 4, 5, 6, 7, 12, 13 or 15 (fetch, load and store misalignment, access faults, breakpoint and page faults), the trap value word (0x343) receives `trap_info`.
- R6: For an exception with code 2 (illegal instruction), the trap value word receives `trap_info`. For every other exception code and for every interrupt, it receives 0. Software can read and write it freely.
- R7: On `mret_strobe` with no trap in the same cycle, the global enable takes the previous-enable bit and the previous-enable bit becomes 1. `ret_pc` always equals the stored exception PC.
- R8: In the status word (0x300), the global enable is bit 3, the previous enable is bit 7 and the saved privilege is bits 12:11. All other bits read 0 and ignore writes, so writing 0xFFFFFFFF reads back 0x00001888.
- R9: The scratch word (0x340) is fully readable and writable and is never changed by a trap or a return.
- R10: If a trap and a CSR write to the status, exception PC, cause or trap value word occur in the same cycle, the trap values win. A trap also wins over a return in the same cycle.
- R11: After reset, the status word reads 0x00001800 and the other four registers read 0. An unmapped address reads 0 with `csr_hit` = 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap request present |
| trap_ready | output | 1 | Block can take a trap request |
| trap_pc | input | 32 | PC at which to resume after the trap |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = synchronous exception |
| trap_code | input | 5 | Exception or interrupt code |
| trap_info | input | 32 | Faulting address or instruction word |
| mret_strobe | input | 1 | Return-from-trap pulse |
| ret_pc | output | 32 | Return target (stored exception PC) |
| irq_enable | output | 1 | Current global interrupt enable |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data |
| csr_hit | output | 1 | Address maps to a register of this block |

## Verification
On every cycle, the assertions check the enable-stack push on a trap, the saved-privilege value, the capture of the aligned exception PC, the interrupt bit of the cause word, a zero trap value after an interrupt, the enable-stack pop on a return, that the scratch word holds without a write to it, and that `trap_ready` stays high once raised.

Only the bench's scenarios can show the following:
- the per-code trap value selection across all 64 cause combinations;
- write masking of the status and cause words;
- trap priority over a colliding CSR write;
- that unmapped writes leave the registers untouched.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam logic [11:0] ADDR_STATUS  = 12'h300;
  localparam logic [11:0] ADDR_SCRATCH = 12'h340;
  localparam logic [11:0] ADDR_EPC     = 12'h341;
  localparam logic [11:0] ADDR_CAUSE   = 12'h342;
  localparam logic [11:0] ADDR_TVAL    = 12'h343;

  localparam int ST_GIE_BIT  = 3;
  localparam int ST_PGIE_BIT = 7;
  localparam int ST_PRV_LO   = 11;

  localparam int unsigned CODE_ILLEGAL = 2;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STATUS, SEL_SCRATCH, SEL_EPC, SEL_CAUSE, SEL_TVAL
  } csr_sel_e;

  // Exception codes whose trap value is the faulting address.
  function automatic logic code_reports_addr(input int unsigned code);
    case (code)
      0, 1, 3, 4, 5, 6, 7, 12, 13, 15: code_reports_addr = 1'b1;
      default:                         code_reports_addr = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mtrap_status.sv
module mtrap_status
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_take,
  input  logic            ret_take,
  input  logic            sw_we,
  input  logic            sw_gie,
  input  logic            sw_pgie,
  input  logic [1:0]      sw_prv,
  output logic            gie,
  output logic            pgie,
  output logic [1:0]      prv,
  output logic [XLEN-1:0] status_word
);
  localparam logic [1:0] PRV_MACHINE = 2'b11;

  // Priority: trap, then return, then software write.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie  <= 1'b0;
      pgie <= 1'b0;
      prv  <= PRV_MACHINE;
    end else if (trap_take) begin
      pgie <= gie;
      gie  <= 1'b0;
      prv  <= PRV_MACHINE;
    end else if (ret_take) begin
      gie  <= pgie;
      pgie <= 1'b1;
    end else if (sw_we) begin
      gie  <= sw_gie;
      pgie <= sw_pgie;
      prv  <= sw_prv;
    end
  end

  always_comb begin
    status_word                          = '0;
    status_word[ST_GIE_BIT]              = gie;
    status_word[ST_PGIE_BIT]             = pgie;
    status_word[ST_PRV_LO+1:ST_PRV_LO]   = prv;
  end
endmodule

// File: rtl/mtrap_tval_sel.sv
module mtrap_tval_sel
  import mtrap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   info,
  output logic [XLEN-1:0]   tval_next
);
  localparam logic [CODE_W-1:0] ILLEGAL = CODE_W'(CODE_ILLEGAL);

  logic pass_info;

  always_comb begin
    pass_info = !is_irq && ((code == ILLEGAL) || code_reports_addr(int'(code)));
    tval_next = pass_info ? info : '0;
  end
endmodule

// File: rtl/mtrap_regs.sv
module mtrap_regs #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_take,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic              trap_is_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   tval_next,
  input  logic              we_scratch,
  input  logic              we_epc,
  input  logic              we_cause,
  input  logic              we_tval,
  input  logic [XLEN-1:0]   wdata,
  output logic [XLEN-1:0]   scratch_q,
  output logic [XLEN-1:0]   epc_q,
  output logic [XLEN-1:0]   cause_q,
  output logic [XLEN-1:0]   tval_q
);
  localparam int          PAD_W      = XLEN - 1 - CODE_W;
  localparam logic [XLEN-1:0] ALIGN_MASK = ~(XLEN'(3));

  logic [XLEN-1:0] cause_from_trap, cause_from_sw;

  always_comb begin
    cause_from_trap = {trap_is_irq, {PAD_W{1'b0}}, trap_code};
    cause_from_sw   = {wdata[XLEN-1], {PAD_W{1'b0}}, wdata[CODE_W-1:0]};
  end

  // Trap-owned registers: trap beats a software write in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
      tval_q  <= '0;
    end else if (trap_take) begin
      epc_q   <= trap_pc & ALIGN_MASK;
      cause_q <= cause_from_trap;
      tval_q  <= tval_next;
    end else begin
      if (we_epc)   epc_q   <= wdata & ALIGN_MASK;
      if (we_cause) cause_q <= cause_from_sw;
      if (we_tval)  tval_q  <= wdata;
    end
  end

  // Software-only register.
  always_ff @(posedge clk) begin
    if (!rst_n)          scratch_q <= '0;
    else if (we_scratch) scratch_q <= wdata;
  end
endmodule

// File: rtl/mtrap_ctrl.sv
module mtrap_ctrl
  import mtrap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_valid,
  output logic              trap_ready,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic              trap_is_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_info,
  input  logic              mret_strobe,
  output logic [XLEN-1:0]   ret_pc,
  output logic              irq_enable,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_hit
);
  logic            ready_q;
  logic            trap_take;
  csr_sel_e        sel;
  logic            st_gie, st_pgie;
  logic [1:0]      st_prv;
  logic [XLEN-1:0] status_word, tval_next;
  logic [XLEN-1:0] scratch_q, epc_q, cause_q, tval_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign trap_ready = ready_q;
  assign trap_take  = trap_valid && ready_q;

  always_comb begin
    case (12'(csr_addr))
      ADDR_STATUS:  sel = SEL_STATUS;
      ADDR_SCRATCH: sel = SEL_SCRATCH;
      ADDR_EPC:     sel = SEL_EPC;
      ADDR_CAUSE:   sel = SEL_CAUSE;
      ADDR_TVAL:    sel = SEL_TVAL;
      default:      sel = SEL_NONE;
    endcase
  end

  mtrap_status #(.XLEN(XLEN)) u_status (
    .clk(clk), .rst_n(rst_n),
    .trap_take(trap_take), .ret_take(mret_strobe),
    .sw_we(csr_we && sel == SEL_STATUS),
    .sw_gie(csr_wdata[ST_GIE_BIT]), .sw_pgie(csr_wdata[ST_PGIE_BIT]),
    .sw_prv(csr_wdata[ST_PRV_LO+1:ST_PRV_LO]),
    .gie(st_gie), .pgie(st_pgie), .prv(st_prv), .status_word(status_word)
  );

  mtrap_tval_sel #(.XLEN(XLEN), .CODE_W(CODE_W)) u_tval_sel (
    .is_irq(trap_is_irq), .code(trap_code), .info(trap_info),
    .tval_next(tval_next)
  );

  mtrap_regs #(.XLEN(XLEN), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .trap_take(trap_take), .trap_pc(trap_pc), .trap_is_irq(trap_is_irq),
    .trap_code(trap_code), .tval_next(tval_next),
    .we_scratch(csr_we && sel == SEL_SCRATCH),
    .we_epc(csr_we && sel == SEL_EPC),
    .we_cause(csr_we && sel == SEL_CAUSE),
    .we_tval(csr_we && sel == SEL_TVAL),
    .wdata(csr_wdata),
    .scratch_q(scratch_q), .epc_q(epc_q), .cause_q(cause_q), .tval_q(tval_q)
  );

  always_comb begin
    case (sel)
      SEL_STATUS:  csr_rdata = status_word;
      SEL_SCRATCH: csr_rdata = scratch_q;
      SEL_EPC:     csr_rdata = epc_q;
      SEL_CAUSE:   csr_rdata = cause_q;
      SEL_TVAL:    csr_rdata = tval_q;
      default:     csr_rdata = '0;
    endcase
  end

  assign csr_hit    = (sel != SEL_NONE);
  assign ret_pc     = epc_q;
  assign irq_enable = st_gie;
endmodule

// File: rtl/mtrap_ctrl_chk.sv
module mtrap_ctrl_chk
  import mtrap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trap_valid,
  input logic              trap_ready,
  input logic [XLEN-1:0]   trap_pc,
  input logic              trap_is_irq,
  input logic              mret_strobe,
  input logic              csr_we,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [XLEN-1:0]   ret_pc,
  input logic              st_gie,
  input logic              st_pgie,
  input logic [1:0]        st_prv,
  input logic [XLEN-1:0]   cause_q,
  input logic [XLEN-1:0]   tval_q,
  input logic [XLEN-1:0]   scratch_q
);
  logic take;
  assign take = trap_valid && trap_ready;

  assert_ready_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ready |=> trap_ready);

  assert_stack_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!st_gie && st_pgie == $past(st_gie) && st_prv == 2'b11));

  assert_epc_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (ret_pc[XLEN-1:2] == $past(trap_pc[XLEN-1:2]) && ret_pc[1:0] == 2'b00));

  assert_cause_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cause_q[XLEN-1] == $past(trap_is_irq));

  assert_irq_tval_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && trap_is_irq) |=> tval_q == '0);

  assert_stack_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_strobe && !take) |=> (st_gie == $past(st_pgie) && st_pgie));

  assert_scratch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_we && 12'(csr_addr) == ADDR_SCRATCH) |=> $stable(scratch_q));
endmodule

bind mtrap_ctrl mtrap_ctrl_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_ready(trap_ready),
  .trap_pc(trap_pc), .trap_is_irq(trap_is_irq), .mret_strobe(mret_strobe),
  .csr_we(csr_we), .csr_addr(csr_addr), .ret_pc(ret_pc),
  .st_gie(st_gie), .st_pgie(st_pgie), .st_prv(st_prv),
  .cause_q(cause_q), .tval_q(tval_q), .scratch_q(scratch_q)
);

// File: tb/tb_mtrap_ctrl.sv
`timescale 1ns/1ps
module tb_mtrap_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_valid = 1'b0, trap_is_irq = 1'b0, mret_strobe = 1'b0;
  logic [31:0] trap_pc = '0, trap_info = '0;
  logic [4:0]  trap_code = '0;
  logic        csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic        trap_ready, irq_enable, csr_hit;
  logic [31:0] ret_pc, csr_rdata;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mtrap_ctrl dut (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_ready(trap_ready),
    .trap_pc(trap_pc), .trap_is_irq(trap_is_irq), .trap_code(trap_code),
    .trap_info(trap_info), .mret_strobe(mret_strobe), .ret_pc(ret_pc),
    .irq_enable(irq_enable), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_hit(csr_hit)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic trap(input logic [31:0] pc, input logic irq,
                      input logic [4:0] code, input logic [31:0] info);
    @(negedge clk);
    trap_valid = 1'b1; trap_pc = pc; trap_is_irq = irq;
    trap_code = code; trap_info = info;
    @(negedge clk);
    trap_valid = 1'b0;
  endtask

  task automatic do_mret();
    @(negedge clk);
    mret_strobe = 1'b1;
    @(negedge clk);
    mret_strobe = 1'b0;
  endtask

  function automatic logic [31:0] exp_tval(input logic irq, input logic [4:0] code,
                                           input logic [31:0] info);
    logic [31:0] addr_mask = 32'h0000_B0FB;
    if (irq) return 32'h0;
    if (code == 5'd2) return info;
    return addr_mask[code] ? info : 32'h0;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check("R1", "ready in reset", {31'b0, trap_ready}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", {31'b0, trap_ready}, 32'h1);
    rd(12'h300, d); check("R11", "reset status", d, 32'h0000_1800);
    rd(12'h340, d); check("R11", "reset scratch", d, 32'h0);
    rd(12'h341, d); check("R11", "reset epc", d, 32'h0);
    rd(12'h342, d); check("R11", "reset cause", d, 32'h0);
    rd(12'h343, d); check("R11", "reset tval", d, 32'h0);

    wr(12'h340, 32'hDEAD_BEEF);
    rd(12'h340, d); check("R9", "scratch write", d, 32'hDEAD_BEEF);

    wr(12'h300, 32'hFFFF_FFFF);
    rd(12'h300, d); check("R8", "status mask", d, 32'h0000_1888);
    check("R8", "irq_enable pin", {31'b0, irq_enable}, 32'h1);

    // Sweep all codes for both trap kinds.
    for (int i = 0; i < 64; i++) begin
      logic        irq  = i[5];
      logic [4:0]  code = i[4:0];
      logic        m    = i[1] ^ i[5];
      logic [31:0] pc   = 32'h8000_0000 + 32'(i * 37);
      logic [31:0] info = 32'hA5A5_0000 ^ 32'(i * 32'h1357);
      logic [31:0] st0  = (32'(m) << 3) | (32'(!m) << 7);
      wr(12'h300, st0);
      rd(12'h300, d); check("R8", "status write", d, st0);
      trap(pc, irq, code, info);
      rd(12'h341, d); check("R3", "epc capture", d, pc & ~32'h3);
      rd(12'h342, d); check("R4", "cause", d, (32'(irq) << 31) | 32'(code));
      rd(12'h343, d); check(irq ? "R6" : (code == 5'd2 ? "R6" : "R5"), "tval", d,
                            exp_tval(irq, code, info));
      rd(12'h300, d); check("R2", "status after trap", d, 32'h1800 | (32'(m) << 7));
      do_mret();
      rd(12'h300, d); check("R7", "status after mret", d, 32'h1880 | (32'(m) << 3));
      check("R7", "ret_pc", ret_pc, pc & ~32'h3);
    end

    rd(12'h340, d); check("R9", "scratch untouched by traps", d, 32'hDEAD_BEEF);

    wr(12'h341, 32'h0000_1003);
    rd(12'h341, d); check("R3", "epc sw align", d, 32'h0000_1000);
    wr(12'h342, 32'hFFFF_FFFF);
    rd(12'h342, d); check("R4", "cause sw mask", d, 32'h8000_001F);
    wr(12'h343, 32'h1234_5678);
    rd(12'h343, d); check("R6", "tval sw write", d, 32'h1234_5678);

    // Collision: trap together with an epc write.
    @(negedge clk);
    trap_valid = 1'b1; trap_pc = 32'h0000_4444; trap_is_irq = 1'b1;
    trap_code = 5'd7; trap_info = 32'h9;
    csr_we = 1'b1; csr_addr = 12'h341; csr_wdata = 32'h0000_8888;
    @(negedge clk);
    trap_valid = 1'b0; csr_we = 1'b0;
    rd(12'h341, d); check("R10", "trap beats epc write", d, 32'h0000_4444);
    rd(12'h342, d); check("R10", "timer irq cause", d, 32'h8000_0007);

    // Collision: trap together with a status write and a return.
    wr(12'h300, 32'h0000_0008);
    @(negedge clk);
    trap_valid = 1'b1; trap_pc = 32'h50; trap_is_irq = 1'b0; trap_code = 5'd3;
    trap_info = 32'h77; mret_strobe = 1'b1;
    csr_we = 1'b1; csr_addr = 12'h300; csr_wdata = 32'h0000_0088;
    @(negedge clk);
    trap_valid = 1'b0; csr_we = 1'b0; mret_strobe = 1'b0;
    rd(12'h300, d); check("R10", "trap beats status write/mret", d, 32'h0000_1880);
    rd(12'h343, d); check("R5", "breakpoint tval", d, 32'h77);

    // Unmapped address.
    wr(12'h7C0, 32'hFFFF_FFFF);
    rd(12'h7C0, d); check("R11", "unmapped read", d, 32'h0);
    check("R11", "unmapped hit", {31'b0, csr_hit}, 32'h0);
    rd(12'h340, d); check("R11", "unmapped write ignored", d, 32'hDEAD_BEEF);
    check("R11", "mapped hit", {31'b0, csr_hit}, 32'h1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule